// File: doc/BRIEF.md
# Bridge Configuration Registers with Alternate Memory Window Decode

This block is a small bank of configuration registers for one function of a bridge, plus an address comparator. It holds three registers. The first is a 32-bit subsystem identifier that accepts exactly one write after each reset. The second is a fixed capability pointer. The third is a 16-bit alternate-base register that carries an enable bit and three 4-bit address nibbles.

A simple register port reaches the bank. It has a byte offset, write data, a write strobe and read data. Reads are combinational from the offset. Writes take effect on the rising clock edge.

A second port takes a 32-bit memory address and returns a hit flag. The flag is high while the address falls in a 256-byte window that the alternate-base register defines, and it is used to claim the access for an internal interrupt-controller register space. Bus protocol handling and the interrupt controller itself sit outside this block.

Top module: `cwr_top`

## Requirements
- R1: After asynchronous reset (rst_n low), the identifier reads 00000000h, the alternate-base register reads 00000000h, and win_hit is low for every address.
- R2: The first write to offset 2Ch after reset stores all 32 data bits. Bits 31:16 hold the subsystem ID and bits 15:0 hold the subsystem vendor ID, and the stored value reads back from 2Ch on the next cycle.
- R3: Once the identifier has been written, later writes to 2Ch leave it unchanged until the next reset. After that reset, one write is accepted again.
- R4: Offset 34h always reads 00000044h, and writes to 34h have no effect.
- R5: Offset 40h holds the enable in bit 15 and nibble X in bits 11:8, nibble Y in bits 7:4 and nibble Z in bits 3:0, all read/write. Bits 14:12 and 31:16 always read zero, and writing ones there has no effect.
- R6: With the enable set, win_hit is high exactly when address bits 31:20 equal FECh and bits 19:16, 15:12 and 11:8 equal X, Y and Z. Bits 7:0 are ignored, so both FECX_YZ00h and FECX_YZFFh hit, and FECX_YZ00h−1 and FECX_YZFFh+1 miss.
- R7: With the enable clear, win_hit stays low for every address, including addresses inside the programmed window.
- R8: Register offsets are decoded on bits 7:2 and bits 1:0 are ignored. Reads of any other offset return zero, and writes to any other offset change no register.
- R9: win_hit is combinational. It follows a change of mem_addr without a clock edge, and it reflects a new alternate-base value from the cycle after the write edge.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_off | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data, combinational from reg_off |
| mem_addr | input | 32 | Memory address to decode |
| win_hit | output | 1 | High while mem_addr lies in the enabled window |

## Verification
The decode is tried with four kinds of address:
- Fully random addresses, which almost never hit and so expose a comparator that claims too much.
- Addresses built from the programmed nibbles with a random low byte, which must all hit and so separate "ignore bits 7:0" from a narrower compare.
- The same addresses with one bit flipped in bits 31:8, which isolate each compared bit in turn.
- Directed addresses one below and one above the window edges, plus window addresses with the enable clear, which separate the enable gating from the address match.

Register traffic mixes random data to every offset, including unmapped ones and ones with odd low bits, with resets in the middle of the run. This shows the write-once lock opening again only through reset.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  localparam int OFF_W   = 8;
  localparam int DATA_W  = 32;
  localparam int MADDR_W = 32;
  localparam int NIB_W   = 4;
  localparam int BASE_W  = 16;
  localparam int WORD_W  = OFF_W - 2;

  localparam logic [WORD_W-1:0] WORD_SUBSYS  = 6'h0B;  // byte 2Ch
  localparam logic [WORD_W-1:0] WORD_CAPPTR  = 6'h0D;  // byte 34h
  localparam logic [WORD_W-1:0] WORD_ALTBASE = 6'h10;  // byte 40h

  localparam logic [7:0]  CAPPTR_VAL = 8'h44;
  localparam int          PREFIX_W   = MADDR_W - 3*NIB_W - 8;
  localparam logic [PREFIX_W-1:0] WIN_PREFIX = 12'hFEC;

  typedef struct packed {
    logic             en;
    logic [2:0]       rsvd;
    logic [NIB_W-1:0] x;
    logic [NIB_W-1:0] y;
    logic [NIB_W-1:0] z;
  } altbase_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SUBSYS,
    SEL_CAPPTR,
    SEL_ALTBASE
  } sel_e;

endpackage

// File: rtl/cwr_subsys_reg.sv
module cwr_subsys_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] id_q,
  output logic         locked
);

  logic [W-1:0] id_d;
  logic         lock_d;
  logic         lock_q;
  logic         id_load;

  // A write is accepted only while the lock is still open.
  assign id_load = wr_en & ~lock_q;

  always_comb begin
    id_d   = id_q;
    lock_d = lock_q;
    if (id_load) begin
      id_d   = wdata;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      id_q   <= id_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  p_first_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q) |=> (id_q == $past(wdata)));

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(id_q));

endmodule

// File: rtl/cwr_altbase_reg.sv
module cwr_altbase_reg
  import cwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wdata,
  output altbase_t          base_q
);

  altbase_t base_d;
  altbase_t wr_val;

  // The reserved field is forced to zero on every write.
  always_comb begin
    wr_val      = altbase_t'(wdata);
    wr_val.rsvd = 3'b000;
  end

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  p_base_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q.en == $past(wdata[15]) && base_q.x == $past(wdata[11:8]) &&
               base_q.y == $past(wdata[7:4]) && base_q.z == $past(wdata[3:0])));

  p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q));

  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    base_q.rsvd == 3'b000);

endmodule

// File: rtl/cwr_win_dec.sv
module cwr_win_dec
  import cwr_pkg::*;
(
  input  altbase_t           base,
  input  logic [MADDR_W-1:0] addr,
  output logic               hit
);

  localparam int LO_W = 8;
  localparam int NIBS = 3;

  logic [NIBS-1:0] nib_eq;
  logic [NIB_W-1:0] prog_nib [NIBS];
  logic             prefix_eq;

  assign prog_nib[0] = base.z;
  assign prog_nib[1] = base.y;
  assign prog_nib[2] = base.x;

  // One comparator per programmable nibble, starting just above the ignored low byte.
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib_eq[g] = (addr[LO_W + g*NIB_W +: NIB_W] == prog_nib[g]);
  end

  assign prefix_eq = (addr[MADDR_W-1 -: PREFIX_W] == WIN_PREFIX);
  assign hit       = base.en & prefix_eq & (&nib_eq);

  wire unused_lowbyte = ^addr[LO_W-1:0] ^ (^base.rsvd);

endmodule

// File: rtl/cwr_top.sv
module cwr_top
  import cwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFF_W-1:0]   reg_off,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [MADDR_W-1:0] mem_addr,
  output logic               win_hit
);

  sel_e              sel;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] id_q;
  logic              id_locked;
  altbase_t          base_q;
  logic              id_we;
  logic              base_we;

  assign word = reg_off[OFF_W-1:2];

  always_comb begin
    unique case (word)
      WORD_SUBSYS:  sel = SEL_SUBSYS;
      WORD_CAPPTR:  sel = SEL_CAPPTR;
      WORD_ALTBASE: sel = SEL_ALTBASE;
      default:      sel = SEL_NONE;
    endcase
  end

  assign id_we   = reg_we & (sel == SEL_SUBSYS);
  assign base_we = reg_we & (sel == SEL_ALTBASE);

  cwr_subsys_reg #(.W(DATA_W)) u_subsys (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (id_we),
    .wdata  (reg_wdata),
    .id_q   (id_q),
    .locked (id_locked)
  );

  cwr_altbase_reg u_altbase (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (base_we),
    .wdata  (reg_wdata[BASE_W-1:0]),
    .base_q (base_q)
  );

  cwr_win_dec u_dec (
    .base (base_q),
    .addr (mem_addr),
    .hit  (win_hit)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_SUBSYS:  reg_rdata = id_q;
      SEL_CAPPTR:  reg_rdata[7:0] = CAPPTR_VAL;
      SEL_ALTBASE: reg_rdata[BASE_W-1:0] = base_q;
      default:     reg_rdata = '0;
    endcase
  end

  wire unused_offlow = ^reg_off[1:0] ^ id_locked;

  p_cap_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word == WORD_CAPPTR) |-> (reg_rdata == 32'h0000_0044));

  p_off_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[15] && (word == WORD_ALTBASE) |-> !win_hit);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0));

  p_hit_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (mem_addr[31:20] == 12'hFEC));

endmodule

// File: tb/cwr_top_bench.sv
`timescale 1ns/1ps
module cwr_top_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_off;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic [31:0] mem_addr;
  logic        win_hit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_id;
  bit          m_locked;
  logic [15:0] m_base;

  cwr_top u_cwr_top (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .mem_addr(mem_addr), .win_hit(win_hit)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [7:0] off);
    case (off[7:2])
      6'h0B:   return m_id;
      6'h0D:   return 32'h0000_0044;
      6'h10:   return {16'h0, m_base};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_hit(input logic [31:0] a);
    return m_base[15] && a[31:20] == 12'hFEC && a[19:16] == m_base[11:8] &&
           a[15:12] == m_base[7:4] && a[11:8] == m_base[3:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    m_id = '0; m_locked = 0; m_base = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_off = off; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    case (off[7:2])
      6'h0B: if (!m_locked) begin m_id = d; m_locked = 1; end
      6'h10: m_base = d[15:0] & 16'h8FFF;
      default: ;
    endcase
  endtask

  task automatic chk_read(input logic [7:0] off, input string req);
    @(negedge clk);
    reg_off = off;
    #1;
    check(reg_rdata == exp_read(off), req, reg_rdata, exp_read(off));
  endtask

  task automatic chk_hit(input logic [31:0] a, input string req);
    mem_addr = a;
    #1;
    check(win_hit == exp_hit(a), req, {31'h0, win_hit}, {31'h0, exp_hit(a)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_off = '0; reg_wdata = '0; reg_we = 1'b0; mem_addr = '0;
    m_id = '0; m_locked = 0; m_base = '0;
    #1;
    // R1 reset state
    chk_read(8'h2C, "R1");
    chk_read(8'h40, "R1");
    chk_hit(32'hFEC0_0000, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R4 fixed pointer, write ignored
    chk_read(8'h34, "R4");
    do_write(8'h34, 32'hFFFF_FFFF);
    chk_read(8'h34, "R4");

    // R2 first write, R3 lock
    do_write(8'h2C, 32'hDEAD_BEEF);
    chk_read(8'h2C, "R2");
    do_write(8'h2C, 32'h1234_5678);
    chk_read(8'h2C, "R3");
    chk_read(8'h2E, "R8");

    // R8 unmapped
    do_write(8'h3C, 32'hFFFF_FFFF);
    chk_read(8'h3C, "R8");
    chk_read(8'h00, "R8");
    chk_read(8'h2C, "R8");
    chk_read(8'h40, "R8");

    // R5 reserved bits
    do_write(8'h40, 32'hFFFF_FFFF);
    chk_read(8'h40, "R5");
    chk_read(8'h42, "R5");

    // R7 disabled window
    do_write(8'h40, 32'h0000_089A);
    chk_hit(32'hFEC8_9A10, "R7");

    // R6 edges, R9 combinational follow
    do_write(8'h41, 32'h0000_889A);
    chk_hit(32'hFEC8_9A00, "R6");
    chk_hit(32'hFEC8_9AFF, "R6");
    chk_hit(32'hFEC8_99FF, "R6");
    chk_hit(32'hFEC8_9B00, "R6");
    chk_hit(32'hFED8_9A00, "R6");
    chk_hit(32'hFEC8_9A55, "R9");
    mem_addr = 32'h0000_0000; #1;
    check(win_hit == 1'b0, "R9", {31'h0, win_hit}, 32'h0);

    // R3 reset reopens the lock
    do_reset();
    chk_read(8'h2C, "R1");
    chk_hit(32'hFEC8_9A00, "R1");
    do_write(8'h2C, 32'hCAFE_0001);
    chk_read(8'h2C, "R3");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: do_write(8'h2C, $urandom);
        1: do_write(8'h40, $urandom);
        2: do_write(8'($urandom), $urandom);
        3: chk_read(8'($urandom), "R8");
        4, 5: begin
          logic [31:0] a;
          a = {12'hFEC, m_base[11:8], m_base[7:4], m_base[3:0], 8'($urandom)};
          if (op == 5) a[8 + ($urandom % 24)] ^= 1'b1;
          chk_hit(a, "R6");
        end
        6: chk_hit($urandom, "R7");
        default: if (($urandom % 40) == 0) do_reset(); else chk_read(8'h2C, "R3");
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule